// File: doc/BRIEF.md
# Real-Time Clock Control Register Command Unit

This block holds the control side of a real-time clock: a rate-select register, a mode/enable register with set, periodic-interrupt, alarm-interrupt, update-interrupt, binary, 24-hour and daylight-saving flags, and three banks of BCD fields for time, date and alarm. The seconds oscillator, the divider chain and the calendar arithmetic are not part of it. The time fields are plain storage loaded and read by commands.

A host issues one command per valid/ready handshake. Each command carries an opcode and four operand bytes. Exactly one cycle later the block returns a status code, the mode-register value that the command produced, and up to four data bytes. Each write-class command changes the mode register through its own fixed mask. An alarm cannot be armed while one is already armed. The update-interrupt flag can never be seen high while the set flag is high. An update-in-progress input blocks the read commands. It also forces a re-initialisation of both registers before the set commands act.

Top module: `rtc_cmd_unit`

## Requirements
- R1: After reset the rate register holds 0x26, the mode register holds 0x02, every time, date and alarm byte is 0x00, and rsp_valid is low.
- R2: The mode register uses bit7 = set/halt, bit6 = periodic enable, bit5 = alarm enable, bit4 = update enable, bit2 = binary, bit1 = 24-hour and bit0 = daylight saving. Whenever bit7 is 1, bit4 is 0. A raw write (opcode 0x06, value in byte 0) of 0xFD therefore leaves 0xED.
- R3: Set-time (0x01) loads seconds, minutes and hours from bytes 0, 1 and 2. It writes the mode register as (old & 0x60) | 0x02 | (byte3 & 0x01) and returns that value with status 0.
- R4: Set-date (0x03) loads the day, month, year and century from bytes 0 to 3. It clears only bit7 of the mode register and returns the new value.
- R5: Set-alarm (0x04) while bit5 is already 1 returns status 1 and the unchanged mode register, and it leaves the alarm bytes untouched.
- R6: Set-alarm (0x04) with bit5 at 0 loads alarm seconds, minutes and hours from bytes 0 to 2. It writes the mode register as (old & 0x7F) | 0x20, and byte 3 of the alarm bank stays 0x00.
- R7: Clear-alarm (0x05) writes the mode register as old & 0x5F and returns the old value.
- R8: Read-time (0x00) and read-date (0x02) return status 1 and zero data while update-in-progress is high. Read-time returns seconds, minutes and hours in bytes 0 to 2, and byte 3 carries only bit0 of the mode register.
- R9: When update-in-progress is high, set-time, set-date and set-alarm first re-initialise the registers (see R11). Set-time and set-alarm then proceed on the re-initialised value. Set-date stops with status 1, returns the re-initialised value and loads no date byte.
- R10: Opcodes above 0x09 return status 2 with zero mode value and zero data, and they change no state.
- R11: Init (0x08) sets the rate register to 0x26 and the mode register to (old & 0x01) | 0x02. Read-regs (0x07) returns the rate register in byte 0 and the mode register in byte 1. Read-alarm (0x09) returns the alarm bank.
- R12: cmd_ready is high after reset. rsp_valid is high exactly in the cycle after each accepted command and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_busy | input | 1 | Update-in-progress flag from the time base |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block accepts a command this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_args | input | 32 | Operand bytes, byte k at bits 8k+7:8k |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | 0 ok, 1 invalid, 2 unimplemented |
| rsp_regb | output | 8 | Mode-register value reported by the command |
| rsp_data | output | 32 | Read data, byte k at bits 8k+7:8k |

## Verification
The assertions check on every cycle that the set and update-enable flags are never high together. They also check that a response follows each accepted command and nothing else, that an armed alarm rejects a new set-alarm without touching the register, that clear-alarm applies its mask, and that busy reads and unknown opcodes give the right status. The effect of each set command on the field banks, the re-initialise-then-proceed sequence under update-in-progress, and the data seen only through later read commands are shown only by the bench's command sequences.

// File: rtl/rtc_cmd_pkg.sv
// Shared constants for the RTC command unit: opcodes, status codes,
// mode-register bit positions and the legalising rule for that register.
// Assumes 8-bit registers and field bytes throughout.
package rtc_cmd_pkg;
    localparam int DW     = 8;
    localparam int NBYTE  = 4;
    localparam int NBANK  = 3;

    localparam logic [7:0] OP_RD_TIME  = 8'h00;
    localparam logic [7:0] OP_SET_TIME = 8'h01;
    localparam logic [7:0] OP_RD_DATE  = 8'h02;
    localparam logic [7:0] OP_SET_DATE = 8'h03;
    localparam logic [7:0] OP_SET_ALM  = 8'h04;
    localparam logic [7:0] OP_CLR_ALM  = 8'h05;
    localparam logic [7:0] OP_WR_MODE  = 8'h06;
    localparam logic [7:0] OP_RD_REGS  = 8'h07;
    localparam logic [7:0] OP_INIT     = 8'h08;
    localparam logic [7:0] OP_RD_ALM   = 8'h09;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_INVALID = 2'd1,
        ST_UNIMPL  = 2'd2
    } status_e;

    localparam int MB_HALT = 7;
    localparam int MB_PIE  = 6;
    localparam int MB_AIE  = 5;
    localparam int MB_UIE  = 4;
    localparam int MB_24H  = 1;
    localparam int MB_DST  = 0;

    localparam int BANK_TIME = 0;
    localparam int BANK_DATE = 1;
    localparam int BANK_ALM  = 2;

    localparam logic [7:0] RATE_INIT = 8'h26;

    // Update-enable cannot stay set while the halt flag is set.
    function automatic logic [7:0] mode_legalize(input logic [7:0] v);
        logic [7:0] r;
        r = v;
        if (v[MB_HALT]) r[MB_UIE] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/rtc_ctl_regs.sv
// Rate and mode registers. Every mode write passes through the legalising
// rule, so update-enable never reads high alongside the halt flag.
// Assumes at most one of mode_we / rate_init per cycle is meaningful
// for each register (they target different registers).
module rtc_ctl_regs
    import rtc_cmd_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_we,
    input  logic [W-1:0] mode_wdata,
    input  logic         rate_init,
    output logic [W-1:0] mode_q,
    output logic [W-1:0] rate_q
);
    localparam logic [W-1:0] MODE_RST = W'(1) << MB_24H;

    // Mode register: reset to 24-hour only, load legalised value on write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_RST;
        else if (mode_we) mode_q <= mode_legalize(mode_wdata);
    end

    // Rate register: fixed value after reset or an init request.
    always_ff @(posedge clk) begin
        if (!rst_n)         rate_q <= W'(RATE_INIT);
        else if (rate_init) rate_q <= W'(RATE_INIT);
    end
endmodule

// File: rtl/rtc_field_banks.sv
// Storage for the time, date and alarm field banks. Each bank holds
// NB bytes and loads all of them from one shared write bus when enabled.
// Assumes the decoder zeroes bytes a bank does not use.
module rtc_field_banks #(
    parameter int W  = 8,
    parameter int NB = 4,
    parameter int NK = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NK-1:0]     bank_we,
    input  logic [NB*W-1:0]   wdata,
    output logic [NK*NB*W-1:0] rdata
);
    localparam int BANK_W = NB * W;

    for (genvar k = 0; k < NK; k++) begin : g_bank
        logic [BANK_W-1:0] bank_q;
        // One bank: clear on reset, load whole word when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)          bank_q <= '0;
            else if (bank_we[k]) bank_q <= wdata;
        end
        assign rdata[k*BANK_W +: BANK_W] = bank_q;
    end
endmodule

// File: rtl/rtc_cmd_decode.sv
// Combinational command decoder. It turns opcode, operands, current
// register state and the update-in-progress flag into register and bank
// write strobes plus the response status, mode value and read data.
// Assumes it is only consulted in a cycle where a command is accepted.
module rtc_cmd_decode
    import rtc_cmd_pkg::*;
#(
    parameter int W  = DW,
    parameter int NB = NBYTE,
    parameter int NK = NBANK
) (
    input  logic [7:0]          op,
    input  logic [NB*W-1:0]     args,
    input  logic                busy,
    input  logic [W-1:0]        mode_q,
    input  logic [W-1:0]        rate_q,
    input  logic [NK*NB*W-1:0]  banks,
    output status_e             status,
    output logic                mode_we,
    output logic [W-1:0]        mode_wdata,
    output logic                rate_init,
    output logic [NK-1:0]       bank_we,
    output logic [NB*W-1:0]     bank_wdata,
    output logic [W-1:0]        rsp_mode,
    output logic [NB*W-1:0]     rsp_data
);
    localparam int BANK_W = NB * W;
    localparam logic [W-1:0] M_24H  = W'(1) << MB_24H;
    localparam logic [W-1:0] M_DST  = W'(1) << MB_DST;
    localparam logic [W-1:0] M_AIE  = W'(1) << MB_AIE;
    localparam logic [W-1:0] M_HALT = W'(1) << MB_HALT;
    localparam logic [W-1:0] M_PIE  = W'(1) << MB_PIE;

    logic [W-1:0]      init_mode;
    logic [W-1:0]      base_mode;
    logic [W-1:0]      nxt_mode;
    logic [BANK_W-1:0] time_b, date_b, alm_b;

    assign time_b    = banks[BANK_TIME*BANK_W +: BANK_W];
    assign date_b    = banks[BANK_DATE*BANK_W +: BANK_W];
    assign alm_b     = banks[BANK_ALM*BANK_W +: BANK_W];
    assign init_mode = (mode_q & M_DST) | M_24H;
    assign base_mode = busy ? init_mode : mode_q;

    // Operand bus to the banks; alarm bank keeps its top byte at zero.
    always_comb begin
        bank_wdata = args;
        if (op == OP_SET_ALM) bank_wdata[(NB-1)*W +: W] = '0;
    end

    // Per-opcode behaviour: strobes, masks, status and response fields.
    always_comb begin
        status    = ST_OK;
        mode_we   = 1'b0;
        rate_init = 1'b0;
        bank_we   = '0;
        nxt_mode  = mode_q;
        rsp_mode  = '0;
        rsp_data  = '0;
        unique case (op)
            OP_RD_TIME: begin
                if (busy) status = ST_INVALID;
                else begin
                    rsp_data = time_b;
                    rsp_data[(NB-1)*W +: W] = mode_q & M_DST;
                end
            end
            OP_SET_TIME: begin
                rate_init = busy;
                nxt_mode  = (base_mode & (M_PIE | M_AIE)) | M_24H
                          | (args[(NB-1)*W +: W] & M_DST);
                mode_we   = 1'b1;
                bank_we[BANK_TIME] = 1'b1;
                rsp_mode  = nxt_mode;
            end
            OP_RD_DATE: begin
                if (busy) status = ST_INVALID;
                else      rsp_data = date_b;
            end
            OP_SET_DATE: begin
                mode_we = 1'b1;
                if (busy) begin
                    rate_init = 1'b1;
                    nxt_mode  = init_mode;
                    status    = ST_INVALID;
                end else begin
                    nxt_mode  = mode_q & ~M_HALT;
                    bank_we[BANK_DATE] = 1'b1;
                end
                rsp_mode = nxt_mode;
            end
            OP_SET_ALM: begin
                if (mode_q[MB_AIE]) begin
                    status   = ST_INVALID;
                    rsp_mode = mode_q;
                end else begin
                    rate_init = busy;
                    nxt_mode  = (base_mode & ~M_HALT) | M_AIE;
                    mode_we   = 1'b1;
                    bank_we[BANK_ALM] = 1'b1;
                    rsp_mode  = nxt_mode;
                end
            end
            OP_CLR_ALM: begin
                nxt_mode = mode_q & ~(M_HALT | M_AIE);
                mode_we  = 1'b1;
                rsp_mode = mode_q;
            end
            OP_WR_MODE: begin
                nxt_mode = args[W-1:0];
                mode_we  = 1'b1;
                rsp_mode = mode_legalize(args[W-1:0]);
            end
            OP_RD_REGS: begin
                rsp_data[0 +: W] = rate_q;
                rsp_data[W +: W] = mode_q;
            end
            OP_INIT: begin
                rate_init = 1'b1;
                nxt_mode  = init_mode;
                mode_we   = 1'b1;
                rsp_mode  = init_mode;
            end
            OP_RD_ALM: rsp_data = alm_b;
            default:   status = ST_UNIMPL;
        endcase
    end

    assign mode_wdata = nxt_mode;
endmodule

// File: rtl/rtc_cmd_unit.sv
// Top of the RTC command unit. Accepts one command per cycle after reset,
// applies it through the decoder to the register and bank storage, and
// registers a one-cycle response. Assumes the host holds no response
// back-pressure; every accepted command answers in the next cycle.
module rtc_cmd_unit
    import rtc_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd_busy,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [7:0]  cmd_op,
    input  logic [31:0] cmd_args,
    output logic        rsp_valid,
    output logic [1:0]  rsp_status,
    output logic [7:0]  rsp_regb,
    output logic [31:0] rsp_data
);
    localparam int W  = DW;
    localparam int NB = NBYTE;
    localparam int NK = NBANK;

    logic              accept;
    status_e           d_status;
    logic              d_mode_we, d_rate_init;
    logic [W-1:0]      d_mode_wdata, d_rsp_mode;
    logic [NK-1:0]     d_bank_we;
    logic [NB*W-1:0]   d_bank_wdata, d_rsp_data;
    logic [W-1:0]      regb_q, rega_q;
    logic [NK*NB*W-1:0] banks_q;

    assign accept = cmd_valid && cmd_ready;

    rtc_cmd_decode #(.W(W), .NB(NB), .NK(NK)) u_dec (
        .op(cmd_op), .args(cmd_args), .busy(upd_busy),
        .mode_q(regb_q), .rate_q(rega_q), .banks(banks_q),
        .status(d_status), .mode_we(d_mode_we), .mode_wdata(d_mode_wdata),
        .rate_init(d_rate_init), .bank_we(d_bank_we),
        .bank_wdata(d_bank_wdata), .rsp_mode(d_rsp_mode),
        .rsp_data(d_rsp_data)
    );

    rtc_ctl_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .mode_we(accept && d_mode_we), .mode_wdata(d_mode_wdata),
        .rate_init(accept && d_rate_init),
        .mode_q(regb_q), .rate_q(rega_q)
    );

    rtc_field_banks #(.W(W), .NB(NB), .NK(NK)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .bank_we(accept ? d_bank_we : '0),
        .wdata(d_bank_wdata), .rdata(banks_q)
    );

    // Ready rises the first cycle out of reset and stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_ready <= 1'b0;
        else        cmd_ready <= 1'b1;
    end

    // Response register: capture decoder results for accepted commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_status <= '0;
            rsp_regb   <= '0;
            rsp_data   <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_status <= d_status;
                rsp_regb   <= d_rsp_mode;
                rsp_data   <= d_rsp_data;
            end
        end
    end
endmodule

// File: rtl/rtc_cmd_unit_chk.sv
// Property checker for rtc_cmd_unit, attached by bind. Observes the
// command handshake, the response and the mode register.
module rtc_cmd_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       upd_busy,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [7:0] cmd_op,
    input logic       rsp_valid,
    input logic [1:0] rsp_status,
    input logic [7:0] regb_q
);
    logic acc;
    assign acc = cmd_valid && cmd_ready;

    // R2
    halt_uie_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regb_q[7] |-> !regb_q[4]);

    // R12
    rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    // R12
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    // R5
    alarm_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 8'h04 && regb_q[5])
        |=> (rsp_status == 2'd1 && regb_q == $past(regb_q)));

    // R7
    clear_alarm_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 8'h05) |=> (regb_q == ($past(regb_q) & 8'h5F)));

    // R8
    busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && upd_busy && (cmd_op == 8'h00 || cmd_op == 8'h02))
        |=> rsp_status == 2'd1);

    // R10
    unimpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op > 8'h09)
        |=> (rsp_status == 2'd2 && regb_q == $past(regb_q)));
endmodule

bind rtc_cmd_unit rtc_cmd_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .upd_busy(upd_busy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .regb_q(regb_q)
);

// File: tb/rtc_cmd_unit_tb.sv
// Scoreboard bench: the driver queues the expected response of every
// command, the monitor compares each response as it appears.
module rtc_cmd_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_busy = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_op = '0;
    logic [31:0] cmd_args = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [7:0]  rsp_regb;
    logic [31:0] rsp_data;

    typedef struct packed {
        logic [1:0]  st;
        logic [7:0]  rb;
        logic [31:0] d;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always #2.5 clk = ~clk;

    rtc_cmd_unit u_dut (
        .clk(clk), .rst_n(rst_n), .upd_busy(upd_busy),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_args(cmd_args), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_regb(rsp_regb), .rsp_data(rsp_data)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] op, input logic [31:0] args,
                        input logic busy, input logic [1:0] est,
                        input logic [7:0] erb, input logic [31:0] ed,
                        input string req);
        exp_q.push_back('{st: est, rb: erb, d: ed});
        tag_q.push_back(req);
        @(negedge clk);
        cmd_op = op; cmd_args = args; upd_busy = busy; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; upd_busy = 1'b0;
    endtask

    // Monitor: pop and compare each response seen between clock edges.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " status"}, 32'(rsp_status), 32'(e.st));
                check({t, " mode"},   32'(rsp_regb),   32'(e.rb));
                check({t, " data"},   rsp_data,        e.d);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R12 cmd_ready after reset", 32'(cmd_ready), 32'd1);
        // R1 reset contents
        send(8'h07, 32'h0, 0, 2'd0, 8'h00, 32'h0000_0226, "R1 read regs");
        send(8'h00, 32'h0, 0, 2'd0, 8'h00, 32'h0, "R1 read time");
        send(8'h09, 32'h0, 0, 2'd0, 8'h00, 32'h0, "R1 read alarm");
        // R2 halt forces update-enable low
        send(8'h06, 32'hFD, 0, 2'd0, 8'hED, 32'h0, "R2 raw write");
        send(8'h07, 32'h0, 0, 2'd0, 8'h00, 32'h0000_ED26, "R2 readback");
        // R3 set time mask
        send(8'h01, 32'h0012_3456, 0, 2'd0, 8'h62, 32'h0, "R3 set time");
        send(8'h00, 32'h0, 0, 2'd0, 8'h00, 32'h0012_3456, "R3 read time");
        // R4 set date clears halt only
        send(8'h06, 32'h7D, 0, 2'd0, 8'h7D, 32'h0, "R4 raw write");
        send(8'h03, 32'h2024_0615, 0, 2'd0, 8'h7D, 32'h0, "R4 set date");
        send(8'h02, 32'h0, 0, 2'd0, 8'h00, 32'h2024_0615, "R4 read date");
        // R5 armed alarm rejects
        send(8'h04, 32'h0007_0809, 0, 2'd1, 8'h7D, 32'h0, "R5 set alarm armed");
        send(8'h09, 32'h0, 0, 2'd0, 8'h00, 32'h0, "R5 alarm untouched");
        // R6 set alarm accepted
        send(8'h06, 32'h5F, 0, 2'd0, 8'h5F, 32'h0, "R6 raw write");
        send(8'h04, 32'hFF07_0809, 0, 2'd0, 8'h7F, 32'h0, "R6 set alarm");
        send(8'h09, 32'h0, 0, 2'd0, 8'h00, 32'h0007_0809, "R6 read alarm");
        // R7 clear alarm returns old value
        send(8'h05, 32'h0, 0, 2'd0, 8'h7F, 32'h0, "R7 clear alarm");
        send(8'h07, 32'h0, 0, 2'd0, 8'h00, 32'h0000_5F26, "R7 readback");
        send(8'h06, 32'hFD, 0, 2'd0, 8'hED, 32'h0, "R7 raw write");
        send(8'h05, 32'h0, 0, 2'd0, 8'hED, 32'h0, "R7 clear alarm halted");
        send(8'h07, 32'h0, 0, 2'd0, 8'h00, 32'h0000_4D26, "R7 readback halted");
        // R9 set time under update: init then proceed
        send(8'h06, 32'h63, 0, 2'd0, 8'h63, 32'h0, "R9 raw write");
        send(8'h01, 32'h0123_5958, 1, 2'd0, 8'h03, 32'h0, "R9 set time busy");
        // R8 only daylight bit in read-time byte 3
        send(8'h06, 32'hE7, 0, 2'd0, 8'hE7, 32'h0, "R8 raw write");
        send(8'h00, 32'h0, 0, 2'd0, 8'h00, 32'h0123_5958, "R8 read time dst only");
        send(8'h00, 32'h0, 1, 2'd1, 8'h00, 32'h0, "R8 read time busy");
        send(8'h02, 32'h0, 1, 2'd1, 8'h00, 32'h0, "R8 read date busy");
        // R9 set date under update: init, invalid, no load
        send(8'h06, 32'h61, 0, 2'd0, 8'h61, 32'h0, "R9 raw write");
        send(8'h03, 32'h1999_1231, 1, 2'd1, 8'h03, 32'h0, "R9 set date busy");
        send(8'h02, 32'h0, 0, 2'd0, 8'h00, 32'h2024_0615, "R9 date unchanged");
        // R9 set alarm under update: init then proceed
        send(8'h06, 32'h41, 0, 2'd0, 8'h41, 32'h0, "R9 raw write");
        send(8'h04, 32'h0001_0203, 1, 2'd0, 8'h23, 32'h0, "R9 set alarm busy");
        send(8'h09, 32'h0, 0, 2'd0, 8'h00, 32'h0001_0203, "R9 read alarm");
        // R10 unimplemented opcodes
        send(8'h0A, 32'hFFFF_FFFF, 0, 2'd2, 8'h00, 32'h0, "R10 op 0A");
        send(8'hFF, 32'hFFFF_FFFF, 0, 2'd2, 8'h00, 32'h0, "R10 op FF");
        send(8'h07, 32'h0, 0, 2'd0, 8'h00, 32'h0000_2326, "R10 state kept");
        // R11 init keeps only daylight bit
        send(8'h06, 32'h62, 0, 2'd0, 8'h62, 32'h0, "R11 raw write");
        send(8'h08, 32'h0, 0, 2'd0, 8'h02, 32'h0, "R11 init no dst");
        send(8'h06, 32'h0B, 0, 2'd0, 8'h0B, 32'h0, "R11 raw write");
        send(8'h08, 32'h0, 0, 2'd0, 8'h03, 32'h0, "R11 init dst");
        send(8'h07, 32'h0, 0, 2'd0, 8'h00, 32'h0000_0326, "R11 readback");
        repeat (3) @(negedge clk);
        check("R12 responses outstanding", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule